// File: doc/BRIEF.md
# Serial Converter Result Reader

This block is the host-side master for a delta-sigma converter that returns its results over a three-signal serial link: an active-low select, a serial clock and a serial data line. When a start request is accepted, the reader pulls the select low. It then watches the data line until the converter drives it low, which means a conversion has finished. After that it generates the serial clock, with a period set by a divider parameter. It captures one data bit on every rising clock edge. There is no pipeline latency: the word it reads belongs to the conversion that has just finished.

A mode input, sampled when the read is accepted, picks the frame length. A short read is 24 clocks: a 4-bit status nibble followed by a 20-bit result, most significant bit first. A long read adds 8 padding clocks so that it stays compatible with older 32-clock hosts. Those padding bits must all read high, and a flag reports any padding bit that reads low. When the last falling clock edge has passed, the select returns high and a one-cycle done pulse presents the status, the result and the flag together. If the converter never signals that it is ready, a wait limit releases the select and raises a timeout pulse instead of a done pulse.

Top module: `adc_result_reader`

## Requirements
- R1: During and after reset, with no request, the select output is high, the serial clock is low, and the busy, done and timeout outputs are low.
- R2: An accepted start drives the select low in the next cycle. No serial clock edge occurs until the data line is sampled low while the select is low.
- R3: The serial clock toggles only while the select is low. Each phase lasts SCK_HALF system clocks. The data line is captured at each rising edge and shifted in most significant bit first.
- R4: In short mode (mode input 0 at start) exactly 24 rising edges are produced. The status output holds the first 4 bits captured and the result output holds the next 20.
- R5: In long mode (mode input 1 at start) exactly 32 rising edges are produced. Status and result come from the first 24 bits. The trailer flag is 1 if and only if any of the last 8 bits read 0.
- R6: Done is high for exactly one cycle, after the final falling edge, and the select is high in that cycle. The status, result and flag outputs keep their values until the next done.
- R7: If the data line stays high for EOC_LIMIT cycles of waiting, the select returns high and timeout pulses for one cycle. No serial clock edge and no done pulse occur in that case.
- R8: A start request while busy is ignored, and that includes its mode input. The read in progress finishes with its original length and result.
- R9: In short mode the trailer flag reads 0 at every done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a read (accepted when idle) |
| long_mode_i | input | 1 | 1 selects the 32-clock padded read, 0 the 24-clock read |
| sdo_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Active-low converter select |
| sck_o | output | 1 | Serial clock to the converter |
| busy_o | output | 1 | A read or wait is in progress |
| done_o | output | 1 | One-cycle pulse, result outputs valid |
| timeout_o | output | 1 | One-cycle pulse, wait for conversion end expired |
| status_o | output | 4 | Status nibble of the last read |
| result_o | output | 20 | 20-bit result of the last read |
| trailer_err_o | output | 1 | A padding bit of the last long read was 0 |

## Verification
On every cycle, the assertions check the following. The serial clock never moves while the select is high or while the reader is still waiting for the conversion to end. Done is a single-cycle pulse with the select high. Done and timeout never occur together. Short reads never flag a trailer error. Each rising edge comes from the divider's rise strobe, and the bit count never passes the long frame length. Only the bench scenarios can show the rest: that the captured values line up with the bits a converter model sends, that exactly 24 or 32 edges appear in each mode, that a single low padding bit is caught, that outputs hold between reads, that the timeout arrives after the configured wait, and that a second start during a read changes nothing.

// File: rtl/adcrd_pkg.sv
package adcrd_pkg;
  localparam int STAT_W   = 4;
  localparam int RES_W    = 20;
  localparam int PAD_W    = 8;
  localparam int BASE_LEN = STAT_W + RES_W;
  localparam int LONG_LEN = BASE_LEN + PAD_W;
  localparam int CNT_W    = $clog2(LONG_LEN + 1);

  typedef enum logic [1:0] {
    RD_IDLE,
    RD_WAIT,
    RD_SHIFT,
    RD_DONE
  } rd_state_e;

  typedef struct packed {
    logic [STAT_W-1:0] status;
    logic [RES_W-1:0]  result;
    logic              pad_bad;
  } rd_result_t;

  // number of serial clocks for the selected mode
  function automatic logic [CNT_W-1:0] frame_bits(input logic long_mode);
    return long_mode ? CNT_W'(LONG_LEN) : CNT_W'(BASE_LEN);
  endfunction

  // split the assembled word into status, result and trailer verdict
  function automatic rd_result_t split_word(input logic [LONG_LEN-1:0] w,
                                            input logic long_mode);
    rd_result_t r;
    logic [BASE_LEN-1:0] head;
    logic [PAD_W-1:0]    pad;
    if (long_mode) begin
      head = w[LONG_LEN-1:PAD_W];
      pad  = w[PAD_W-1:0];
    end else begin
      head = w[BASE_LEN-1:0];
      pad  = '1;
    end
    r.status  = head[BASE_LEN-1 -: STAT_W];
    r.result  = head[RES_W-1:0];
    r.pad_bad = ~&pad;
    return r;
  endfunction
endpackage

// File: rtl/adcrd_sck_gen.sv
module adcrd_sck_gen #(
  parameter int HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sck,
  output logic rise_stb,
  output logic fall_stb
);
  localparam int PW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [PW-1:0] ph_q;
  logic          sck_q;
  logic          ph_end;

  assign ph_end = (ph_q == PW'(HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= '0;
      sck_q <= 1'b0;
    end else if (!run) begin
      ph_q  <= '0;
      sck_q <= 1'b0;
    end else if (ph_end) begin
      ph_q  <= '0;
      sck_q <= ~sck_q;
    end else begin
      ph_q  <= ph_q + 1'b1;
    end
  end

  assign rise_stb = run & ph_end & ~sck_q;
  assign fall_stb = run & ph_end & sck_q;
  assign sck      = sck_q;

  // R3
  rise_from_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck_q) |-> $past(rise_stb));
  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_stb && fall_stb));
endmodule

// File: rtl/adcrd_shifter.sv
module adcrd_shifter #(
  parameter int W  = 32,
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          shift_en,
  input  logic          din,
  output logic [W-1:0]  word,
  output logic [CW-1:0] nbits
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word  <= '0;
      nbits <= '0;
    end else if (clear) begin
      word  <= '0;
      nbits <= '0;
    end else if (shift_en) begin
      word  <= {word[W-2:0], din};
      nbits <= nbits + 1'b1;
    end
  end

  // R4
  shift_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nbits <= CW'(W));
endmodule

// File: rtl/adcrd_eoc_watch.sv
module adcrd_eoc_watch #(
  parameter int LIMIT = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic sdo,
  output logic eoc,
  output logic expired
);
  localparam int TW = $clog2(LIMIT + 1);

  logic [TW-1:0] wait_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   wait_q <= '0;
    else if (!arm)                wait_q <= '0;
    else if (wait_q != TW'(LIMIT)) wait_q <= wait_q + 1'b1;
  end

  assign eoc     = arm & ~sdo;
  assign expired = arm & sdo & (wait_q == TW'(LIMIT - 1));

  // R7
  wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm |-> (wait_q < TW'(LIMIT)));
endmodule

// File: rtl/adc_result_reader.sv
module adc_result_reader #(
  parameter int SCK_HALF  = 4,
  parameter int EOC_LIMIT = 4096
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        long_mode_i,
  input  logic        sdo_i,
  output logic        cs_n_o,
  output logic        sck_o,
  output logic        busy_o,
  output logic        done_o,
  output logic        timeout_o,
  output logic [3:0]  status_o,
  output logic [19:0] result_o,
  output logic        trailer_err_o
);
  import adcrd_pkg::*;

  rd_state_e            state_q, state_d;
  logic                 long_q;
  logic                 timeout_q;
  rd_result_t           res_q;

  logic                 start_accept;
  logic                 arm_wait;
  logic                 run_sck;
  logic                 rise_stb, fall_stb;
  logic                 eoc_seen, wait_expired;
  logic                 frame_full;
  logic                 shift_en;
  logic                 last_fall;
  logic [LONG_LEN-1:0]  word;
  logic [CNT_W-1:0]     nbits;

  assign start_accept = (state_q == RD_IDLE) & start_i;
  assign arm_wait     = (state_q == RD_WAIT);
  assign run_sck      = (state_q == RD_SHIFT);
  assign frame_full   = (nbits == frame_bits(long_q));
  assign shift_en     = run_sck & rise_stb & ~frame_full;
  assign last_fall    = run_sck & fall_stb & frame_full;

  adcrd_sck_gen #(.HALF(SCK_HALF)) u_sck (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_sck),
    .sck      (sck_o),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  adcrd_shifter #(.W(LONG_LEN), .CW(CNT_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (start_accept),
    .shift_en (shift_en),
    .din      (sdo_i),
    .word     (word),
    .nbits    (nbits)
  );

  adcrd_eoc_watch #(.LIMIT(EOC_LIMIT)) u_eoc (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm     (arm_wait),
    .sdo     (sdo_i),
    .eoc     (eoc_seen),
    .expired (wait_expired)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      RD_IDLE:  if (start_i) state_d = RD_WAIT;
      RD_WAIT: begin
        if (eoc_seen)          state_d = RD_SHIFT;
        else if (wait_expired) state_d = RD_IDLE;
      end
      RD_SHIFT: if (last_fall) state_d = RD_DONE;
      RD_DONE:  state_d = RD_IDLE;
      default:  state_d = RD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= RD_IDLE;
      long_q    <= 1'b0;
      timeout_q <= 1'b0;
      res_q     <= '0;
    end else begin
      state_q   <= state_d;
      timeout_q <= arm_wait & ~eoc_seen & wait_expired;
      if (start_accept) long_q <= long_mode_i;
      if (last_fall)    res_q  <= split_word(word, long_q);
    end
  end

  assign cs_n_o        = (state_q == RD_IDLE) | (state_q == RD_DONE);
  assign busy_o        = (state_q != RD_IDLE);
  assign done_o        = (state_q == RD_DONE);
  assign timeout_o     = timeout_q;
  assign status_o      = res_q.status;
  assign result_o      = res_q.result;
  assign trailer_err_o = res_q.pad_bad;

  // R2
  no_clock_in_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RD_WAIT) |-> !sck_o);
  // R3
  sck_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sck_o |-> !cs_n_o);
  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R6
  done_cs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> cs_n_o);
  // R7
  timeout_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> (cs_n_o && !done_o));
  // R9
  short_no_pad_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !long_q) |-> !trailer_err_o);
  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o && !(arm_wait && wait_expired)) |=> busy_o);
endmodule

// File: tb/sim_adc_result_reader.sv
module sim_adc_result_reader;
  localparam int HALF  = 2;
  localparam int LIMIT = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        long_mode_i = 1'b0;
  logic        sdo_i = 1'b1;
  logic        cs_n_o, sck_o, busy_o, done_o, timeout_o, trailer_err_o;
  logic [3:0]  status_o;
  logic [19:0] result_o;

  always #2.5 clk = ~clk;

  adc_result_reader #(.SCK_HALF(HALF), .EOC_LIMIT(LIMIT)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .long_mode_i(long_mode_i),
    .sdo_i(sdo_i), .cs_n_o(cs_n_o), .sck_o(sck_o), .busy_o(busy_o),
    .done_o(done_o), .timeout_o(timeout_o), .status_o(status_o),
    .result_o(result_o), .trailer_err_o(trailer_err_o)
  );

  int tests = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  typedef struct {
    logic [3:0]  st;
    logic [19:0] dat;
    logic        err;
    int          edges;
  } exp_t;
  exp_t exp_q[$];

  // converter model
  logic [31:0] m_word = '1;
  int          m_delay = 0;
  bit          m_never = 1'b0;
  int          m_idx = 31;
  int          m_cnt = 0;
  logic        m_prev_sck = 1'b0;
  int          rises = 0;
  int          dones = 0;
  int          touts = 0;

  always @(negedge clk) begin
    if (cs_n_o) begin
      sdo_i <= 1'b1;
      m_cnt <= 0;
      m_idx <= 31;
    end else if (m_never || m_cnt < m_delay) begin
      sdo_i <= 1'b1;
      m_cnt <= m_cnt + 1;
    end else begin
      if (m_prev_sck && !sck_o && m_idx > 0) begin
        sdo_i <= m_word[m_idx-1];
        m_idx <= m_idx - 1;
      end else if (m_prev_sck && !sck_o) begin
        sdo_i <= 1'b1;
      end else begin
        sdo_i <= m_word[m_idx];
      end
    end
    if (sck_o && !m_prev_sck) rises <= rises + 1;
    m_prev_sck <= sck_o;
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && timeout_o) touts++;
    if (rst_n && done_o) begin
      dones++;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6 unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(status_o == e.st, "R4 status", status_o, e.st);
        chk(result_o == e.dat, "R4 result", result_o, e.dat);
        chk(trailer_err_o == e.err, "R5 trailer flag", trailer_err_o, e.err);
        chk(rises == e.edges, "R5 edge count", rises, e.edges);
        chk(cs_n_o == 1'b1, "R6 cs high at done", cs_n_o, 1);
      end
    end
  end

  task automatic pulse_start(input logic lm);
    @(negedge clk);
    start_i = 1'b1;
    long_mode_i = lm;
    @(negedge clk);
    start_i = 1'b0;
    long_mode_i = 1'b0;
  endtask

  task automatic do_read(input logic lm, input logic [23:0] frame,
                         input logic [7:0] pad, input int dly);
    exp_t e;
    frame[23] = 1'b0;
    m_word  = {frame, pad};
    m_delay = dly;
    m_never = 1'b0;
    rises   = 0;
    e.st    = frame[23:20];
    e.dat   = frame[19:0];
    e.err   = lm && (pad != 8'hFF);
    e.edges = lm ? 32 : 24;
    exp_q.push_back(e);
    pulse_start(lm);
    // R2: select low one cycle after acceptance, no clock yet
    chk(cs_n_o == 1'b0, "R2 cs low after start", cs_n_o, 0);
    chk(sck_o == 1'b0, "R2 no sck before eoc", sck_o, 0);
    while (busy_o) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cs_n_o == 1'b1, "R1 cs", cs_n_o, 1);
    chk(sck_o == 1'b0, "R1 sck", sck_o, 0);
    chk(busy_o == 1'b0 && done_o == 1'b0 && timeout_o == 1'b0, "R1 flags",
        {busy_o, done_o, timeout_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(cs_n_o == 1'b1, "R1 idle cs", cs_n_o, 1);

    // R4 short reads, varied patterns and wait lengths
    do_read(1'b0, 24'h3A5C3F, 8'hFF, 3);
    do_read(1'b0, 24'h7FFFFF, 8'hFF, 1);
    do_read(1'b0, 24'h000001, 8'hFF, 10);
    // R5 long reads, clean and with one low padding bit
    do_read(1'b1, 24'h512345, 8'hFF, 5);
    do_read(1'b1, 24'h6ABCDE, 8'hEF, 2);
    do_read(1'b1, 24'h000000, 8'hFE, 4);
    // R9 short read after a flagged long read clears the flag
    do_read(1'b0, 24'h1F0F0F, 8'h00, 2);

    // R6 outputs hold after done
    repeat (12) @(negedge clk);
    chk(result_o == 20'hF0F0F && status_o == 4'h1, "R6 hold",
        {status_o, result_o}, {4'h1, 20'hF0F0F});

    // R8 start while busy ignored (long mode request must not apply)
    begin
      exp_t e;
      m_word = {24'h2C0DE5, 8'h00};
      m_delay = 6; m_never = 1'b0; rises = 0;
      e.st = 4'h2; e.dat = 20'hC0DE5; e.err = 1'b0; e.edges = 24;
      exp_q.push_back(e);
      pulse_start(1'b0);
      repeat (20) @(negedge clk);
      pulse_start(1'b1);
      while (busy_o) @(negedge clk);
      repeat (6) @(negedge clk);
      chk(busy_o == 1'b0, "R8 no second read", busy_o, 0);
    end

    // R7 timeout when converter never signals end of conversion
    begin
      int n;
      int t0;
      n = 0;
      t0 = touts;
      m_never = 1'b1; rises = 0;
      pulse_start(1'b0);
      while (touts == t0 && n < LIMIT + 20) begin
        @(negedge clk);
        n++;
      end
      chk(touts == t0 + 1, "R7 timeout pulse", touts - t0, 1);
      chk(n >= LIMIT - 1 && n <= LIMIT + 2, "R7 timeout delay", n, LIMIT);
      chk(rises == 0, "R7 no sck", rises, 0);
      chk(cs_n_o == 1'b1, "R7 cs released", cs_n_o, 1);
      m_never = 1'b0;
    end

    repeat (5) @(negedge clk);
    chk(dones == 8, "R6 done count", dones, 8);
    chk(exp_q.size() == 0, "R4 scoreboard empty", exp_q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule